// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit general-register value into a binary64 floating-point value in one registered stage. A 2-bit kind field says how the source is read: signed or unsigned, 32 or 64 bits wide. A 32-bit source comes from the low half of the input word. A precision select picks the result format. In double mode the value is rounded to a 53-bit significand. In single mode it is rounded to a 24-bit significand, which gives binary32 precision, and then written out exactly as a binary64 bit pattern. Single mode always keeps the low 29 fraction bits at zero.

Along with the result the block returns a 5-bit class code and three status bits: rounded-up, inexact and sticky-inexact. It also returns a summary-exception bit and a status write-enable. A 32-bit source converted to double is always exact. In that case the write-enable stays low, so the floating-point status held around the block is left alone. Integer sources can only produce +zero, positive normal and negative normal, so the class logic has just those three outcomes. Instruction decode and condition-register update sit outside this block.

Top module: `cvt_int2fp`

## Requirements
- R1: The kind field `in_kind` selects the source: 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. A 32-bit source is bits 31:0 of `in_data`, and bits 63:32 are ignored.
- R2: With `in_single` = 0 and `in_kind` below 2, the result is the exact value. `out_stat_we` is 0, and `out_class`, `out_fr`, `out_fi`, `out_xx` and `out_fx` are all 0.
- R3: The rounding mode `in_rmode` is 00 = nearest-even, 01 = toward zero, 10 = toward +infinity, 11 = toward -infinity. It applies to the significand width of the selected precision: 53 bits for double, 24 bits for single.
- R4: With `in_single` = 1 the value is rounded to binary32 precision and delivered as the equal binary64 pattern, so result bits 28:0 are zero.
- R5: When `out_stat_we` is 1, `out_class` is 00010 for +zero, 00100 for a positive normal and 01000 for a negative normal. In single mode the class comes from the binary32 value.
- R6: `out_fr` is 1 exactly when rounding increased the magnitude. `out_fi` is 1 exactly when the result differs from the source value.
- R7: Whenever the result is inexact, both the sticky-inexact bit `out_xx` and the summary-exception bit `out_fx` are 1.
- R8: `out_stat_we` is 1 for every single-mode conversion and for every 64-bit source.
- R9: The most negative signed 64-bit value, and the most negative signed 32-bit value, convert to their exact negative powers of two with no overflow.
- R10: Results appear one clock after an accepted input, with `out_valid` high for exactly that cycle. Reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 64 | Integer source word |
| in_kind | input | 2 | Source kind: 0 s32, 1 u32, 2 s64, 3 u64 |
| in_single | input | 1 | 1 = round to binary32 and widen, 0 = binary64 |
| in_rmode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | binary64 result pattern |
| out_class | output | 5 | Result class code |
| out_fr | output | 1 | Rounding increased the magnitude |
| out_fi | output | 1 | Result is inexact |
| out_xx | output | 1 | Sticky inexact |
| out_fx | output | 1 | Summary exception raised |
| out_stat_we | output | 1 | Status fields are to be written |

## Verification
A wrong leading-zero count or a bad negation of the most negative value shows up as a wrong exponent or sign in `out_result` in the cycle right after the input. A wrong guard or sticky decision appears as a one-ulp error together with a mismatched `out_fr` or `out_fi`. Values just above and just below the 24-bit and 53-bit significand limits, exact ties and the all-ones words expose these faults in all four rounding modes. A stuck status write-enable shows on the first 32-bit double-mode conversion, because its status fields must be exactly zero.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int XLEN    = 64;
  localparam int LZ_W    = $clog2(XLEN) + 1;
  localparam int DP_MANT = 53;
  localparam int SP_MANT = 24;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = DP_MANT - 1;
  localparam int DP_BIAS = 1023;
  localparam int CLS_W   = 5;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_POS  = 2'b10,
    RM_NEG  = 2'b11
  } rmode_e;

  localparam logic [CLS_W-1:0] CLS_NONE  = 5'b00000;
  localparam logic [CLS_W-1:0] CLS_PZERO = 5'b00010;
  localparam logic [CLS_W-1:0] CLS_PNORM = 5'b00100;
  localparam logic [CLS_W-1:0] CLS_NNORM = 5'b01000;
endpackage

// File: rtl/cvt_prep.sv
// Source extension and magnitude: sign/zero extend, then negate if negative.
module cvt_prep
  import cvt_pkg::*;
(
  input  logic [XLEN-1:0] data_i,
  input  logic [1:0]      kind_i,
  output logic [XLEN-1:0] mag_o,
  output logic            neg_o,
  output logic            zero_o
);
  logic [XLEN-1:0] ext;

  always_comb begin
    if (kind_i[1])      ext = data_i;
    else if (kind_i[0]) ext = {{(XLEN/2){1'b0}}, data_i[XLEN/2-1:0]};
    else                ext = {{(XLEN/2){data_i[XLEN/2-1]}}, data_i[XLEN/2-1:0]};
    neg_o  = ~kind_i[0] & ext[XLEN-1];
    // two's complement of the most negative value is itself, read as unsigned
    mag_o  = neg_o ? (~ext + 1'b1) : ext;
    zero_o = (ext == '0);
  end
endmodule

// File: rtl/cvt_lzc.sv
// Leading-zero counter; returns W for an all-zero word.
module cvt_lzc #(
  parameter int W   = 64,
  parameter int CNT = $clog2(W) + 1
) (
  input  logic [W-1:0]   val_i,
  output logic [CNT-1:0] lz_o
);
  always_comb begin
    lz_o = CNT'(W);
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) lz_o = CNT'(W - 1 - i);
    end
  end
endmodule

// File: rtl/cvt_round.sv
// Rounds a normalised word to MANT significand bits; fraction left-aligned.
module cvt_round
  import cvt_pkg::*;
#(
  parameter int MANT = DP_MANT
) (
  input  logic [XLEN-1:0]   norm_i,
  input  logic              neg_i,
  input  logic [1:0]        rmode_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic              carry_o,
  output logic              up_o,
  output logic              inexact_o
);
  localparam int PAD = FRAC_W - (MANT - 1);

  logic [MANT-1:0]   keep;
  logic              guard;
  logic              sticky;
  logic [MANT:0]     sum;
  logic [FRAC_W-1:0] frac_raw;

  always_comb begin
    keep      = norm_i[XLEN-1 -: MANT];
    guard     = norm_i[XLEN-1-MANT];
    sticky    = |norm_i[XLEN-2-MANT:0];
    inexact_o = guard | sticky;
    case (rmode_e'(rmode_i))
      RM_NEAR: up_o = guard & (sticky | keep[0]);
      RM_ZERO: up_o = 1'b0;
      RM_POS:  up_o = inexact_o & ~neg_i;
      default: up_o = inexact_o & neg_i;
    endcase
    sum      = {1'b0, keep} + {{MANT{1'b0}}, up_o};
    carry_o  = sum[MANT];
    // on carry the significand is 10..0: shift right by one
    frac_raw = carry_o ? FRAC_W'(sum[MANT-1:1]) : FRAC_W'(sum[MANT-2:0]);
    frac_o   = frac_raw << PAD;
  end
endmodule

// File: rtl/cvt_int2fp.sv
module cvt_int2fp
  import cvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [XLEN-1:0]   in_data,
  input  logic [1:0]        in_kind,
  input  logic              in_single,
  input  logic [1:0]        in_rmode,
  output logic              out_valid,
  output logic [XLEN-1:0]   out_result,
  output logic [CLS_W-1:0]  out_class,
  output logic              out_fr,
  output logic              out_fi,
  output logic              out_xx,
  output logic              out_fx,
  output logic              out_stat_we
);
  localparam int NPREC = 2;  // index 0 = double, 1 = single
  localparam int EXP_MAX = XLEN - 1;

  logic [XLEN-1:0]   mag, norm;
  logic              neg, zero;
  logic [LZ_W-1:0]   lz;
  logic [LZ_W-1:0]   e_unb;
  logic [FRAC_W-1:0] rd_frac  [NPREC];
  logic              rd_carry [NPREC];
  logic              rd_up    [NPREC];
  logic              rd_inex  [NPREC];

  logic [XLEN-1:0]   result_n;
  logic [CLS_W-1:0]  class_n;
  logic [EXP_W-1:0]  exp_b;
  logic              we_n, fr_n, fi_n;
  logic              single_q;

  cvt_prep i_prep (
    .data_i (in_data),
    .kind_i (in_kind),
    .mag_o  (mag),
    .neg_o  (neg),
    .zero_o (zero)
  );

  cvt_lzc #(.W(XLEN), .CNT(LZ_W)) i_lzc (
    .val_i (mag),
    .lz_o  (lz)
  );

  always_comb begin
    norm  = mag << lz[LZ_W-2:0];
    e_unb = LZ_W'(EXP_MAX) - lz;
  end

  for (genvar g = 0; g < NPREC; g++) begin : g_prec
    cvt_round #(.MANT(g == 0 ? DP_MANT : SP_MANT)) i_round (
      .norm_i    (norm),
      .neg_i     (neg),
      .rmode_i   (in_rmode),
      .frac_o    (rd_frac[g]),
      .carry_o   (rd_carry[g]),
      .up_o      (rd_up[g]),
      .inexact_o (rd_inex[g])
    );
  end

  // next-state logic
  always_comb begin
    we_n  = in_single | in_kind[1];
    exp_b = EXP_W'(DP_BIAS) + EXP_W'(e_unb) + EXP_W'(rd_carry[in_single]);
    if (zero) result_n = '0;
    else      result_n = {neg, exp_b, rd_frac[in_single]};
    fr_n = we_n & ~zero & rd_up[in_single];
    fi_n = we_n & ~zero & rd_inex[in_single];
    if (!we_n)     class_n = CLS_NONE;
    else if (zero) class_n = CLS_PZERO;
    else if (neg)  class_n = CLS_NNORM;
    else           class_n = CLS_PNORM;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_result  <= result_n;
      out_class   <= class_n;
      out_fr      <= fr_n;
      out_fi      <= fi_n;
      out_xx      <= fi_n;
      out_fx      <= fi_n;
      out_stat_we <= we_n;
      single_q    <= in_single;
    end
  end

  // assertions
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R10
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R10
  AST_EXACT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_stat_we |-> !out_fi && !out_fr && !out_fx && out_class == CLS_NONE);  // R2
  AST_UP_IS_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fr |-> out_fi);  // R6
  AST_STICKY_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fi |-> out_xx && out_fx && out_stat_we);  // R7
  AST_SINGLE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && single_q |-> out_result[XLEN-SP_MANT-12:0] == '0 && out_stat_we);  // R4
  AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_class));  // R5
  AST_CLASS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_stat_we |-> ((out_class == CLS_NNORM) == out_result[XLEN-1]));  // R5
endmodule

// File: tb/test_cvt_int2fp.sv
module test_cvt_int2fp;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_data;
  logic [1:0]  in_kind;
  logic        in_single;
  logic [1:0]  in_rmode;
  logic        out_valid;
  logic [63:0] out_result;
  logic [4:0]  out_class;
  logic        out_fr, out_fi, out_xx, out_fx, out_stat_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [63:0] res;
    logic [4:0]  cls;
    logic fr, fi, xx, fx, we;
  } exp_t;

  typedef struct {
    exp_t  e;
    string tag;
  } item_t;

  item_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  cvt_int2fp i_cvt_int2fp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_kind(in_kind), .in_single(in_single), .in_rmode(in_rmode),
    .out_valid(out_valid), .out_result(out_result), .out_class(out_class),
    .out_fr(out_fr), .out_fi(out_fi), .out_xx(out_xx), .out_fx(out_fx),
    .out_stat_we(out_stat_we)
  );

  // Reference: find top bit, divide down, compare remainder against half.
  function automatic exp_t model(input logic [63:0] d, input logic [1:0] ty,
                                 input logic sgl, input logic [1:0] rm);
    exp_t r;
    logic [63:0] v, mag, q, rem, half;
    logic neg, up, inex;
    int p, m, sh;
    logic [10:0] ex;
    r = '0;
    v = ty[1] ? d : (ty[0] ? {32'b0, d[31:0]} : {{32{d[31]}}, d[31:0]});
    neg = !ty[0] && v[63];
    mag = neg ? (~v + 64'd1) : v;
    r.we = sgl | ty[1];
    if (mag == 0) begin
      r.cls = r.we ? 5'b00010 : 5'b00000;
      return r;
    end
    p = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) p = i;
    m = sgl ? 24 : 53;
    up = 1'b0; inex = 1'b0;
    if (p < m) q = mag << (m - 1 - p);
    else begin
      sh = p - m + 1;
      q = mag >> sh;
      rem = mag & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      inex = (rem != 0);
      case (rm)
        2'b00: up = (rem > half) || (rem == half && q[0]);
        2'b01: up = 1'b0;
        2'b10: up = inex && !neg;
        default: up = inex && neg;
      endcase
    end
    q = q + {63'd0, up};
    if (q[m]) begin q = q >> 1; p++; end
    ex = 11'(1023 + p);
    r.res = {neg, ex, sgl ? {q[22:0], 29'b0} : q[51:0]};
    r.cls = r.we ? (neg ? 5'b01000 : 5'b00100) : 5'b00000;
    r.fr = r.we & up;
    r.fi = r.we & inex;
    r.xx = r.fi;
    r.fx = r.fi;
    return r;
  endfunction

  task automatic send(input logic [63:0] d, input logic [1:0] ty, input logic sgl,
                      input logic [1:0] rm, input bit use_k, input logic [63:0] want,
                      input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_kind = ty; in_single = sgl; in_rmode = rm;
    it.e = model(d, ty, sgl, rm);
    if (use_k) it.e.res = want;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      item_t it;
      exp_t got;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected out_valid, actual=1 expected=0");
      end else begin
        it = sb.pop_front();
        got = {out_result, out_class, out_fr, out_fi, out_xx, out_fx, out_stat_we};
        if (got !== it.e) begin
          errors++;
          $display("FAIL %s: actual res=%h cls=%b fr=%b fi=%b xx=%b fx=%b we=%b expected res=%h cls=%b fr=%b fi=%b xx=%b fx=%b we=%b",
                   it.tag, out_result, out_class, out_fr, out_fi, out_xx, out_fx, out_stat_we,
                   it.e.res, it.e.cls, it.e.fr, it.e.fi, it.e.xx, it.e.fx, it.e.we);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_kind = '0; in_single = 1'b0; in_rmode = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: reset out_valid actual=%b expected=0", out_valid);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2 R1: 32-bit double-mode, exact, quiet status; upper half ignored
    send(64'h0000_0000_FFFF_FFFF, 2'd0, 1'b0, 2'b00, 1, 64'hBFF0_0000_0000_0000, "R2 s32 -1");
    send(64'h0000_0000_FFFF_FFFF, 2'd1, 1'b0, 2'b11, 1, 64'h41EF_FFFF_FFE0_0000, "R1 u32 max");
    send(64'hDEAD_BEEF_0000_0005, 2'd0, 1'b0, 2'b10, 1, 64'h4014_0000_0000_0000, "R1 upper ignored");
    send(64'h1234_5678_8000_0000, 2'd0, 1'b0, 2'b00, 1, 64'hC1E0_0000_0000_0000, "R9 s32 min");
    // R9 R8
    send(64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'b00, 1, 64'hC3E0_0000_0000_0000, "R9 s64 min");
    // R3 R6 R7: all-ones u64, round up vs truncate
    send(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'b00, 1, 64'h43F0_0000_0000_0000, "R6 u64 max near");
    send(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'b01, 1, 64'h43EF_FFFF_FFFF_FFFF, "R3 u64 max zero");
    idle(1);
    // R4 R5: single-mode
    send(64'd1,          2'd2, 1'b1, 2'b00, 1, 64'h3FF0_0000_0000_0000, "R4 single one");
    send(64'd0,          2'd0, 1'b1, 2'b00, 1, 64'h0,                   "R5 single zero");
    send(64'd0,          2'd3, 1'b0, 2'b10, 1, 64'h0,                   "R5 u64 zero");
    send(64'h0100_0001,  2'd2, 1'b1, 2'b00, 1, 64'h4170_0000_0000_0000, "R3 single near down");
    send(64'h0100_0001,  2'd2, 1'b1, 2'b10, 1, 64'h4170_0000_2000_0000, "R3 single pos up");
    send(64'h0100_0003,  2'd2, 1'b1, 2'b00, 1, 64'h4170_0000_4000_0000, "R3 single tie even");
    send(-64'sd16777217, 2'd2, 1'b1, 2'b11, 1, 64'hC170_0000_2000_0000, "R3 single neg down");
    send(-64'sd16777217, 2'd2, 1'b1, 2'b10, 1, 64'hC170_0000_0000_0000, "R3 single neg toward pos");
    send(64'h8000_0000,  2'd1, 1'b1, 2'b01, 1, 64'h41E0_0000_0000_0000, "R4 single u32 exact");
    send(64'h0020_0000_0000_0001, 2'd2, 1'b0, 2'b00, 0, 64'h0, "R6 double 2^53+1");
    send(64'h0020_0000_0000_0003, 2'd2, 1'b0, 2'b00, 0, 64'h0, "R6 double tie");
    idle(2);

    // random mix with bubbles
    for (int n = 0; n < 400; n++) begin
      logic [63:0] d;
      d = {$urandom, $urandom} >> ($urandom % 64);
      if ($urandom % 2) d = -d;
      send(d, 2'($urandom), 1'($urandom), 2'($urandom), 0, 64'h0, "R3 random");
      if ($urandom % 4 == 0) idle(1);
    end
    idle(3);

    // R10: pipeline drained, nothing left, output idle
    checks++;
    if (sb.size() != 0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: pending=%0d out_valid=%b expected pending=0 out_valid=0", sb.size(), out_valid);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule